// File: doc/BRIEF.md
# Shifted Decimating Accumulator Channel

This block is the datapath for one analog input channel. Each clock it takes an unsigned ADC sample and widens it into a 32-bit accumulator domain. A fixed left offset equal to the accumulator width minus the output width is applied first. A programmable right shift of 0 to 15 steps follows. With a shift of zero, the ADC sample's least significant bit lands on the least significant bit of the decimated output. The shifted value is registered, so there is one cycle of latency ahead of the accumulator.

Two strobes from an external timing unit drive the accumulator. `win_start` closes the current decimation window and opens a new one. `win_add` folds the registered shifted sample into the window total. A window can sum many samples (averaging) or hold a single sample (plain selection). When a window closes, the upper output-width bits of the total go to the output register. An accumulator that overflows is pinned to all ones until the next window opens.

Top module: `dec_accum_channel`

## Requirements
- R1: While reset is asserted, and for two clocks after its release, `dec_sample` is 0 and the window total is 0.
- R2: With `shift_amt` = 0, a window holding one sample A yields `dec_sample` = A, so the ADC LSB is output bit 0.
- R3: The sample's contribution to the total is (A << (32 - OUT_W)) >> `shift_amt`, where `shift_amt` is sampled in the same cycle as A. `dec_sample` is bits [31:32-OUT_W] of the total.
- R4: `win_start` and `win_add` high together load the total with the shifted sample and drop the previous total.
- R5: `win_add` high with `win_start` low adds the shifted sample to the running total.
- R6: On a clock with `win_start` high, `dec_sample` takes the upper bits of the total as it stood before that clock. On every other clock, `dec_sample` holds its value.
- R7: If an addition carries out of bit 31, the total becomes all ones. Further additions keep it there until the next `win_start`, and a closed saturated window yields `dec_sample` of all ones.
- R8: `win_start` high with `win_add` low clears the total to 0.
- R9: `win_add` at clock edge k uses the ADC sample and shift amount that were present at edge k-1.
- R10: ADC data is unsigned. A set MSB counts as a large positive value, for example 0x2000 with shift 1 gives 0x1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| adc_in | input | ADC_W | Unsigned ADC sample |
| shift_amt | input | SHIFT_W | Right-shift steps applied after the fixed left offset |
| win_start | input | 1 | Close the current window and open a new one |
| win_add | input | 1 | Fold the registered shifted sample into the total |
| dec_sample | output | OUT_W | Decimated sample of the last closed window |

## Verification
A corrupted total, such as a missed clear, a wrong load on start or a lost carry, does not appear at the ports until the next `win_start`. It then shows up in `dec_sample` one clock later, so every window is closed and compared. An error in the shift register timing shifts each sample by one cycle. Directed cases change the sample on the very cycle `win_add` rises, which exposes that error. Saturation is checked by running a long window past 2^32 and by checking that the following window starts clean.

// File: rtl/dec_accum_pkg.sv
package dec_accum_pkg;
  localparam int unsigned ACC_W_DEF   = 32;
  localparam int unsigned ADC_W_DEF   = 14;
  localparam int unsigned OUT_W_DEF   = 24;
  localparam int unsigned SHIFT_W_DEF = 4;

  typedef enum logic [1:0] {
    ACC_HOLD  = 2'b00,
    ACC_ADD   = 2'b01,
    ACC_CLEAR = 2'b10,
    ACC_LOAD  = 2'b11
  } acc_op_e;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dac_shift_stage.sv
module dac_shift_stage #(
  parameter int unsigned ADC_W   = 14,
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned OUT_W   = 24,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADC_W-1:0]   adc_in,
  input  logic [SHIFT_W-1:0] shift_amt,
  output logic [ACC_W-1:0]   shifted
);
  localparam int unsigned PRE = ACC_W - OUT_W;

  logic [ACC_W-1:0] wide;
  logic [ACC_W-1:0] shifted_d;
  logic [ACC_W-1:0] shifted_q;

  always_comb begin
    wide      = {{(ACC_W-ADC_W){1'b0}}, adc_in} << PRE;
    shifted_d = wide >> shift_amt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shifted_q <= '0;
    else        shifted_q <= shifted_d;
  end

  assign shifted = shifted_q;
endmodule

// File: rtl/dac_accumulator.sv
module dac_accumulator
  import dec_accum_pkg::*;
#(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_start,
  input  logic             win_add,
  input  logic [ACC_W-1:0] shifted,
  output logic [ACC_W-1:0] total
);
  acc_op_e          op;
  logic [ACC_W-1:0] base;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] total_d;
  logic [ACC_W-1:0] total_q;
  logic             total_en;

  always_comb begin
    op       = acc_op_e'({win_start, win_add});
    base     = (op == ACC_LOAD) ? '0 : total_q;
    sum      = {1'b0, base} + {1'b0, shifted};
    total_en = (op != ACC_HOLD);
    case (op)
      ACC_ADD, ACC_LOAD: total_d = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
      ACC_CLEAR:         total_d = '0;
      default:           total_d = total_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        total_q <= '0;
    else if (total_en) total_q <= total_d;
  end

  assign total = total_q;
endmodule

// File: rtl/dac_out_stage.sv
module dac_out_stage #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_start,
  input  logic [ACC_W-1:0] total,
  output logic [OUT_W-1:0] dec_sample
);
  logic [OUT_W-1:0] out_d;
  logic [OUT_W-1:0] out_q;

  always_comb out_d = total[ACC_W-1 -: OUT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_q <= '0;
    else if (win_start) out_q <= out_d;
  end

  assign dec_sample = out_q;
endmodule

// File: rtl/dec_accum_channel.sv
module dec_accum_channel
  import dec_accum_pkg::*;
#(
  parameter int unsigned ADC_W   = ADC_W_DEF,
  parameter int unsigned ACC_W   = ACC_W_DEF,
  parameter int unsigned OUT_W   = OUT_W_DEF,
  parameter int unsigned SHIFT_W = SHIFT_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADC_W-1:0]   adc_in,
  input  logic [SHIFT_W-1:0] shift_amt,
  input  logic               win_start,
  input  logic               win_add,
  output logic [OUT_W-1:0]   dec_sample
);
  logic             rst_sync_n;
  logic [ACC_W-1:0] shifted;
  logic [ACC_W-1:0] total;

  dac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dac_shift_stage #(
    .ADC_W(ADC_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .adc_in    (adc_in),
    .shift_amt (shift_amt),
    .shifted   (shifted)
  );

  dac_accumulator #(.ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .win_start (win_start),
    .win_add   (win_add),
    .shifted   (shifted),
    .total     (total)
  );

  dac_out_stage #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .win_start  (win_start),
    .total      (total),
    .dec_sample (dec_sample)
  );
endmodule

// File: rtl/dec_accum_checker.sv
module dec_accum_checker #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned OUT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             win_start,
  input logic             win_add,
  input logic [ACC_W-1:0] shifted,
  input logic [ACC_W-1:0] total,
  input logic [OUT_W-1:0] dec_sample
);
  // R6: output only moves on a window close
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !win_start |=> $stable(dec_sample));

  // R6: captured value is the prior total's upper bits
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> dec_sample == $past(total[ACC_W-1 -: OUT_W]));

  // R8: start without add leaves an empty total
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start && !win_add) |=> total == '0);

  // R7: saturated total stays pinned while adding
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (win_add && !win_start && (&total)) |=> (&total));

  // R5: adding an unsigned value never lowers the total
  a_r5_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
    (win_add && !win_start) |=> total >= $past(total));

  // R4: load takes the shifted sample exactly
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (win_add && win_start) |=> total == $past(shifted));

  // R1: reset state
  always @(negedge clk)
    if (!rst_n) a_r1_reset: assert (total == '0 && dec_sample == '0);
endmodule

bind dec_accum_channel dec_accum_checker #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .win_start  (win_start),
  .win_add    (win_add),
  .shifted    (shifted),
  .total      (total),
  .dec_sample (dec_sample)
);

// File: tb/tb_dec_accum_channel.sv
module tb_dec_accum_channel;
  localparam int ADC_W = 14, ACC_W = 32, OUT_W = 24, SHIFT_W = 4;
  localparam int PRE = ACC_W - OUT_W;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [ADC_W-1:0]   adc_in = '0;
  logic [SHIFT_W-1:0] shift_amt = '0;
  logic               win_start = 1'b0;
  logic               win_add = 1'b0;
  logic [OUT_W-1:0]   dec_sample;

  int n_vec = 0, n_bad = 0;
  logic [ACC_W-1:0] m_acc = '0, m_sh = '0;
  logic [OUT_W-1:0] m_out = '0;
  bit done = 0;

  always #2 clk = ~clk;

  dec_accum_channel dut (
    .clk(clk), .rst_n(rst_n), .adc_in(adc_in), .shift_amt(shift_amt),
    .win_start(win_start), .win_add(win_add), .dec_sample(dec_sample)
  );

  function automatic logic [ACC_W-1:0] f_shift(input logic [ADC_W-1:0] a, input logic [SHIFT_W-1:0] s);
    logic [ACC_W-1:0] w;
    w = {{(ACC_W-ADC_W){1'b0}}, a};
    return (w << PRE) >> s;
  endfunction

  task automatic chk(input string tag, input logic [OUT_W-1:0] exp);
    n_vec++;
    if (dec_sample !== exp) begin
      n_bad++;
      $display("FAIL %s: dec_sample=%h expected=%h", tag, dec_sample, exp);
    end
  endtask

  // one clock: drive at negedge, update model after posedge, compare at next negedge
  task automatic cyc(input bit s, input bit i, input logic [ADC_W-1:0] a, input logic [SHIFT_W-1:0] sh);
    logic [ACC_W:0] t;
    win_start = s; win_add = i; adc_in = a; shift_amt = sh;
    @(posedge clk);
    if (s) m_out = m_acc[ACC_W-1 -: OUT_W];
    if (i) begin
      t = {1'b0, (s ? {ACC_W{1'b0}} : m_acc)} + {1'b0, m_sh};
      m_acc = t[ACC_W] ? {ACC_W{1'b1}} : t[ACC_W-1:0];
    end else if (s) m_acc = '0;
    m_sh = f_shift(a, sh);
    @(negedge clk);
    chk("R6 model", m_out);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: dec_sample=%h expected=finished", dec_sample);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1 in reset", '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 after release", '0);

    // R2: shift zero aligns LSB
    cyc(0,0,14'h3FFF,0); cyc(1,1,0,0); cyc(1,0,0,0);
    chk("R2", 24'h003FFF);
    // R3: shift 3 of 1000 gives 125
    cyc(0,0,14'd1000,3); cyc(1,1,0,0); cyc(1,0,0,0);
    chk("R3", 24'd125);
    // R9: sample changes on the add cycle; previous one is used
    cyc(0,0,14'd100,0); cyc(1,1,14'd7,0); cyc(1,0,0,0);
    chk("R9", 24'd100);
    // R4: load on start+add drops the earlier total
    cyc(0,0,14'd5,0); cyc(0,1,14'd6,0); cyc(1,1,14'd9,0); cyc(1,0,0,0);
    chk("R4", 24'd6);
    // R5: three adds
    cyc(0,0,14'd10,0); cyc(1,1,14'd20,0); cyc(0,1,14'd30,0); cyc(0,1,0,0); cyc(1,0,0,0);
    chk("R5", 24'd60);
    // R10: unsigned MSB
    cyc(0,0,14'h2000,1); cyc(1,1,0,0); cyc(1,0,0,0);
    chk("R10", 24'h001000);
    // R7: 1100 max samples overflow 2^32
    cyc(0,0,14'h3FFF,0); cyc(1,1,14'h3FFF,0);
    for (int k = 0; k < 1100; k++) cyc(0,1,14'h3FFF,0);
    cyc(1,0,0,0);
    chk("R7 saturated", 24'hFFFFFF);
    // R8: start without add clears; next close gives 0
    cyc(1,0,0,0);
    chk("R8", 24'd0);

    // constrained random windows
    for (int w = 0; w < 400; w++) begin
      int len = $urandom_range(1, 12);
      for (int k = 0; k < len; k++)
        cyc(k == 0, ($urandom_range(0, 3) != 0), ADC_W'($urandom), SHIFT_W'($urandom));
    end
    cyc(1,0,0,0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule